// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames on a single line and presents each one as a byte, together with sticky error flags and a data-ready indication for a host. It runs from a system clock and a separate enable tick that occurs at sixteen times the bit rate. The block does not generate that tick, and it has no transmit side.

A frame opens with a low start bit and closes with a high stop bit, and its bits arrive least significant first. Two framings are supported. In the standard framing the frame carries either eight data bits, or seven data bits followed by a parity bit of selectable sense. In the multiprocessor framing the frame carries eight data bits followed by an address/data marker bit, and parity is never checked. Only the first stop bit is examined, so a sender may append further stop bits without effect.

When a frame completes, any error flags it caused are raised first, and the full flag follows one cycle later. The host clears the full flag with a read strobe. It clears the error flags with a separate clear strobe. An interrupt request follows the full flag while the interrupt enable is high.

Top module: `srx_top`

## Requirements
- R1: While `rx_en` is 0 the receiver stays idle: no frame is captured and `rx_full` stays 0.
- R2: Standard framing without parity (`mode_mp`=0, `par_en`=0): after a low start bit, eight data bits are taken least significant first and appear on `rx_data`; `rx_adbit` reads 0.
- R3: Standard framing with parity (`mode_mp`=0, `par_en`=1): seven data bits are followed by a parity bit. `rx_data[6:0]` holds the data and `rx_data[7]` reads 0. With `par_odd`=0 the data and parity bits together must hold an even number of ones, and with `par_odd`=1 an odd number. A mismatch sets `err_parity`.
- R4: Multiprocessor framing (`mode_mp`=1): eight data bits are followed by a ninth bit, which appears on `rx_adbit`. `err_parity` is never set in this framing, whatever `par_en` is.
- R5: After the falling edge, the start bit is sampled again eight ticks later. If the line is high then, the event counts as noise: the receiver returns to idle and sets no flag. A following valid frame is received normally.
- R6: Each data bit is sampled once, at mid-bit. Only the first stop bit is sampled. A low level there sets `err_frame`, and the byte is still delivered. A new start bit may follow a single stop bit directly.
- R7: When a frame sets an error flag while `rx_full` is 0, the flag rises exactly one clock cycle before `rx_full` rises.
- R8: If a frame completes while `rx_full` is 1, `err_overrun` is set, and `rx_data` and `rx_adbit` keep the earlier frame.
- R9: A one-cycle `rd_stb` clears `rx_full` on the next clock edge, unless a new frame is posting in that same cycle.
- R10: `rx_irq` is high exactly when `rx_full` is 1 and `irq_en` is 1. Both are registered outputs and change on the same edge.
- R11: `err_parity`, `err_overrun` and `err_frame` stay set until `err_clr` is pulsed. A new error arriving in the same cycle as the clear takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| mode_mp | input | 1 | 0 selects the standard framing, 1 the multiprocessor framing |
| par_en | input | 1 | Enables parity in the standard framing |
| par_odd | input | 1 | Parity sense: 0 for even, 1 for odd |
| irq_en | input | 1 | Receive interrupt enable |
| rd_stb | input | 1 | Host read strobe; clears the full flag |
| err_clr | input | 1 | Clears all three error flags |
| rx_data | output | 8 | Received byte |
| rx_adbit | output | 1 | Received address/data marker bit |
| rx_full | output | 1 | Received data is waiting for the host |
| err_parity | output | 1 | Sticky parity error flag |
| err_overrun | output | 1 | Sticky overrun error flag |
| err_frame | output | 1 | Sticky framing error flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The stop bit is sampled mid-bit, after a two-stage line synchronizer and the bit timer. The error flags then rise within a few system cycles, and `rx_full` and `rx_irq` rise exactly one cycle after the flags. All of this settles well before the end of the stop bit. The bench therefore drives every stop bit for a full bit period and checks data and flags at the falling clock edge after the frame. A monitor on falling edges stamps the cycle in which an error flag rises and the cycle in which the full flag rises, and the bench requires these stamps to differ by exactly one. After a read strobe or a clear strobe, the next falling edge must already show the flag cleared, because each strobe takes effect on a single register edge.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_t;

  // Result of one completed frame, handed from the framer to the status logic
  typedef struct packed {
    logic [7:0] data;
    logic       adbit;
    logic       perr;
    logic       ferr;
  } frame_res_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       line,
  input  logic       mode_mp,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done,
  output frame_res_t res
);

  localparam int            CW      = $clog2(OSR);
  localparam int            BW      = $clog2(DW + 2);
  localparam logic [CW-1:0] MID     = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST    = CW'(OSR - 1);
  localparam logic [BW-1:0] N_PLAIN = BW'(DW);
  localparam logic [BW-1:0] N_EXTRA = BW'(DW + 1);

  rx_state_t      state;
  logic [CW-1:0]  tcnt;
  logic [BW-1:0]  bcnt;
  logic [DW:0]    shreg;
  logic [BW-1:0]  nbits;
  logic [DW:0]    shnext;

  assign nbits  = mode_mp ? N_EXTRA : N_PLAIN;
  assign shnext = {line, shreg[DW:1]};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= ST_IDLE;
      tcnt  <= '0;
      bcnt  <= '0;
      shreg <= '0;
      done  <= 1'b0;
      res   <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            tcnt <= '0;
            if (!line) state <= ST_START;
          end
          ST_START: begin
            if (tcnt == MID) begin
              tcnt <= '0;
              bcnt <= '0;
              state <= line ? ST_IDLE : ST_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (tcnt == LAST) begin
              tcnt  <= '0;
              bcnt  <= bcnt + 1'b1;
              // In the 8-bit framings the bits end in shreg[DW:1]
              shreg <= (mode_mp || bcnt != N_PLAIN - 1'b1) ? shnext : {shnext[DW:1], 1'b0};
              if (bcnt == nbits - 1'b1) state <= ST_STOP;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (tcnt == LAST) begin
              tcnt     <= '0;
              state    <= ST_IDLE;
              done     <= 1'b1;
              res.ferr <= !line;
              if (mode_mp) begin
                res.data  <= shreg[DW-1:0];
                res.adbit <= shreg[DW];
                res.perr  <= 1'b0;
              end else if (par_en) begin
                res.data  <= {1'b0, shreg[DW-1:1]};
                res.adbit <= 1'b0;
                res.perr  <= (^shreg[DW:1]) ^ par_odd;
              end else begin
                res.data  <= shreg[DW:1];
                res.adbit <= 1'b0;
                res.perr  <= 1'b0;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       done,
  input  frame_res_t res,
  input  logic       rd_stb,
  input  logic       err_clr,
  input  logic       irq_en,
  output logic [7:0] data_q,
  output logic       adbit_q,
  output logic       full_q,
  output logic       perr_q,
  output logic       oerr_q,
  output logic       ferr_q,
  output logic       irq_q,
  output logic       set_pend
);

  logic occupied;
  logic full_next;

  assign occupied  = full_q | set_pend;
  assign full_next = set_pend | (full_q & !rd_stb);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      adbit_q  <= 1'b0;
      full_q   <= 1'b0;
      perr_q   <= 1'b0;
      oerr_q   <= 1'b0;
      ferr_q   <= 1'b0;
      irq_q    <= 1'b0;
      set_pend <= 1'b0;
    end else begin
      set_pend <= done;
      perr_q   <= (perr_q & !err_clr) | (done & res.perr);
      ferr_q   <= (ferr_q & !err_clr) | (done & res.ferr);
      oerr_q   <= (oerr_q & !err_clr) | (done & occupied);
      if (done && !occupied) begin
        data_q  <= res.data;
        adbit_q <= res.adbit;
      end
      full_q <= full_next;
      irq_q  <= full_next & irq_en;
    end
  end

endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       os_tick,
  input  logic       serial_in,
  input  logic       mode_mp,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       irq_en,
  input  logic       rd_stb,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_adbit,
  output logic       rx_full,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       err_frame,
  output logic       rx_irq
);

  logic       line_s;
  logic       frame_done;
  logic       set_pend;
  frame_res_t frame_res;

  srx_sync #(.STAGES(SYNC_STGS), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (serial_in),
    .d_out (line_s)
  );

  srx_frame #(.OSR(OSR), .DW(8)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .en      (rx_en),
    .tick    (os_tick),
    .line    (line_s),
    .mode_mp (mode_mp),
    .par_en  (par_en),
    .par_odd (par_odd),
    .done    (frame_done),
    .res     (frame_res)
  );

  srx_status u_status (
    .clk      (clk),
    .rst      (rst),
    .done     (frame_done),
    .res      (frame_res),
    .rd_stb   (rd_stb),
    .err_clr  (err_clr),
    .irq_en   (irq_en),
    .data_q   (rx_data),
    .adbit_q  (rx_adbit),
    .full_q   (rx_full),
    .perr_q   (err_parity),
    .oerr_q   (err_overrun),
    .ferr_q   (err_frame),
    .irq_q    (rx_irq),
    .set_pend (set_pend)
  );

endmodule

// File: rtl/srx_chk.sv
module srx_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_en,
  input logic       mode_mp,
  input logic       rd_stb,
  input logic       err_clr,
  input logic [7:0] rx_data,
  input logic       rx_full,
  input logic       rx_irq,
  input logic       err_parity,
  input logic       err_overrun,
  input logic       err_frame,
  input logic       set_pend,
  input logic       frame_done
);

  p_disabled_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && $past(!rx_en)) |-> !frame_done);

  p_no_parity_mp_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_mp && $past(mode_mp)) |-> !$rose(err_parity));

  p_err_then_full_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(err_frame) && !rx_full) |=> rx_full);

  p_overrun_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> $stable(rx_data));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !set_pend) |=> !rx_full);

  p_irq_needs_full_r10: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);

  p_frame_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (err_frame && !err_clr) |=> err_frame);

  p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (err_overrun && !err_clr) |=> err_overrun);

endmodule

bind srx_top srx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_en       (rx_en),
  .mode_mp     (mode_mp),
  .rd_stb      (rd_stb),
  .err_clr     (err_clr),
  .rx_data     (rx_data),
  .rx_full     (rx_full),
  .rx_irq      (rx_irq),
  .err_parity  (err_parity),
  .err_overrun (err_overrun),
  .err_frame   (err_frame),
  .set_pend    (set_pend),
  .frame_done  (frame_done)
);

// File: tb/tb_srx_top.sv
module tb_srx_top;

  localparam int OSR  = 16;
  localparam int TDIV = 2;
  localparam int BITC = OSR * TDIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0, os_tick = 1'b0, serial_in = 1'b1;
  logic       mode_mp = 1'b0, par_en = 1'b0, par_odd = 1'b0, irq_en = 1'b0;
  logic       rd_stb = 1'b0, err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_adbit, rx_full, err_parity, err_overrun, err_frame, rx_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int full_rise = -1;
  int err_rise = -1;
  logic pf = 1'b0, pe = 1'b0;
  int tcnt = 0;

  srx_top dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .os_tick(os_tick), .serial_in(serial_in),
    .mode_mp(mode_mp), .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en),
    .rd_stb(rd_stb), .err_clr(err_clr), .rx_data(rx_data), .rx_adbit(rx_adbit),
    .rx_full(rx_full), .err_parity(err_parity), .err_overrun(err_overrun),
    .err_frame(err_frame), .rx_irq(rx_irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tcnt    <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    os_tick <= (tcnt == 0);
  end

  // Stamp the cycle in which the full flag and any error flag rise
  always @(negedge clk) begin
    logic anyerr;
    anyerr = err_parity | err_overrun | err_frame;
    cyc = cyc + 1;
    if (rx_full && !pf) full_rise = cyc;
    if (anyerr && !pe) err_rise = cyc;
    pf = rx_full;
    pe = anyerr;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BITC) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] bits, input int nb, input logic stop_lvl);
    @(negedge clk);
    full_rise = -1;
    err_rise  = -1;
    serial_in = 1'b0;
    wait_bits(1);
    for (int i = 0; i < nb; i++) begin
      serial_in = bits[i];
      wait_bits(1);
    end
    serial_in = stop_lvl;
    if (stop_lvl) begin
      wait_bits(1);
    end else begin
      for (int k = 0; k < 2 * BITC && !err_frame; k++) @(negedge clk);
      serial_in = 1'b1;
      wait_bits(1);
    end
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    chk(rx_full == 0, "R9 reset full", rx_full, 0);
    chk({err_parity, err_overrun, err_frame} == 0, "R11 reset flags",
        {err_parity, err_overrun, err_frame}, 0);
    chk(rx_irq == 0, "R10 reset irq", rx_irq, 0);

    // R1: disabled receiver ignores a frame
    send_frame(9'h0A5, 8, 1'b1);
    wait_bits(1);
    chk(rx_full == 0, "R1 disabled", rx_full, 0);
    chk(rx_data == 8'h00, "R1 data untouched", rx_data, 0);

    // R2 / R9 / R10: all bytes, standard framing without parity
    rx_en = 1'b1;
    for (int b = 0; b < 256; b++) begin
      irq_en = b[0];
      send_frame({1'b0, 8'(b)}, 8, 1'b1);
      chk(rx_full == 1, "R2 full", rx_full, 1);
      chk(rx_data == 8'(b), "R2 data", rx_data, b);
      chk(rx_adbit == 0, "R2 adbit", rx_adbit, 0);
      chk({err_parity, err_overrun, err_frame} == 0, "R2 no errors",
          {err_parity, err_overrun, err_frame}, 0);
      chk(rx_irq == irq_en, "R10 irq", rx_irq, irq_en);
      pulse_rd();
      chk(rx_full == 0, "R9 read clears", rx_full, 0);
      chk(rx_irq == 0, "R10 irq drops", rx_irq, 0);
    end
    irq_en = 1'b0;

    // R3 / R7 / R11: parity framing, both senses, some corrupted
    par_en = 1'b1;
    for (int v = 0; v < 128; v++) begin
      logic bad, p;
      par_odd = v[0] ^ v[3];
      bad     = (v % 5 == 0);
      p       = (^v[6:0]) ^ par_odd ^ bad;
      send_frame({1'b0, p, 7'(v)}, 8, 1'b1);
      chk(rx_data == {1'b0, 7'(v)}, "R3 data", rx_data, v);
      chk(err_parity == bad, "R3 parity flag", err_parity, bad);
      if (bad) begin
        chk(full_rise == err_rise + 1, "R7 order", full_rise - err_rise, 1);
        pulse_rd();
        chk(err_parity == 1, "R11 sticky after read", err_parity, 1);
        pulse_clr();
        chk(err_parity == 0, "R11 cleared", err_parity, 0);
      end else begin
        pulse_rd();
      end
    end

    // R4: multiprocessor framing, parity never reported
    mode_mp = 1'b1;
    par_en  = 1'b1;
    par_odd = 1'b1;
    for (int v = 0; v < 32; v++) begin
      logic [7:0] d;
      d = 8'(v * 37 + 5);
      send_frame({v[0], d}, 9, 1'b1);
      chk(rx_data == d, "R4 data", rx_data, d);
      chk(rx_adbit == v[0], "R4 adbit", rx_adbit, v[0]);
      chk(err_parity == 0, "R4 no parity", err_parity, 0);
      pulse_rd();
    end
    mode_mp = 1'b0;
    par_en  = 1'b0;
    par_odd = 1'b0;

    // R6 / R7 / R11: low stop bit
    send_frame(9'h03C, 8, 1'b0);
    chk(err_frame == 1, "R6 frame error", err_frame, 1);
    chk(rx_data == 8'h3C, "R6 data kept", rx_data, 8'h3C);
    chk(full_rise == err_rise + 1, "R7 order frame", full_rise - err_rise, 1);
    pulse_rd();
    wait_bits(2);
    chk(rx_full == 0, "R6 no spurious frame", rx_full, 0);
    chk(err_frame == 1, "R11 frame sticky", err_frame, 1);
    pulse_clr();
    chk(err_frame == 0, "R11 frame cleared", err_frame, 0);

    // R6: back-to-back frames with one stop bit
    send_frame(9'h011, 8, 1'b1);
    chk(rx_data == 8'h11, "R6 first of pair", rx_data, 8'h11);
    pulse_rd();
    send_frame(9'h022, 8, 1'b1);
    chk(rx_data == 8'h22, "R6 second of pair", rx_data, 8'h22);
    chk({err_overrun, err_frame} == 0, "R6 pair clean", {err_overrun, err_frame}, 0);
    pulse_rd();

    // R8: overrun keeps older byte
    send_frame(9'h05A, 8, 1'b1);
    send_frame(9'h0C3, 8, 1'b1);
    chk(err_overrun == 1, "R8 overrun", err_overrun, 1);
    chk(rx_data == 8'h5A, "R8 older kept", rx_data, 8'h5A);
    chk(rx_full == 1, "R8 still full", rx_full, 1);
    pulse_clr();
    chk(err_overrun == 0, "R11 overrun cleared", err_overrun, 0);
    pulse_rd();

    // R5: short low glitch rejected, then a valid frame
    @(negedge clk) serial_in = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    serial_in = 1'b1;
    wait_bits(3);
    chk(rx_full == 0, "R5 glitch no frame", rx_full, 0);
    chk(err_frame == 0, "R5 glitch no flag", err_frame, 0);
    send_frame(9'h096, 8, 1'b1);
    chk(rx_data == 8'h96, "R5 after glitch", rx_data, 8'h96);
    chk(rx_irq == 0, "R10 irq disabled", rx_irq, 0);
    @(negedge clk) irq_en = 1'b1;
    @(negedge clk);
    chk(rx_irq == 1, "R10 irq enabled late", rx_irq, 1);
    pulse_rd();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule